// File: doc/BRIEF.md
# Staged Reset Sequencer

This block sequences the resets of a serial link path made of ordered stages. A typical order is the wait for the PLL to lock, then the analog front end, then the digital datapath. It takes two kinds of asynchronous active-high request: one full-initialization request, and one request per stage. For each stage it drives a reset output and keeps it high for a hold time set by a parameter. When the work it was asked to do is finished, it raises a done flag.

A mode input selects how far a stage request runs:

- In sequential mode, the requested stage runs and then every stage after it runs in ascending order.
- In single mode, only the requested stage runs, for its own single-mode hold time.

The mode input is trusted only after it has been steady for a configurable setup window. The full-initialization request always runs in sequential mode. A build-time switch produces the transmit-side variant, which has sequential mode only. An override input, when high, suppresses all automatic sequencing.

Top module: `stage_reset_seq`

## Requirements
- R1: A change on any request, mode or override input first affects the outputs at the third rising clock edge after it is applied. Two of those edges are synchronizer stages and one is the registered sequencer.
- R2: While a synchronized request is high, the reset output of the requested stage stays high and `done_o` stays low. The sequencer leaves this held state only after the request returns low.
- R3: In sequential mode, after release, stage i stays in reset for `SEQ_HOLD[i]` more cycles. Each later stage then follows in ascending order for its own `SEQ_HOLD` count. At most one bit of `stage_rst_o` is ever high, and bit i belongs to stage i.
- R4: In single mode, only the requested stage runs. It stays in reset for `SINGLE_HOLD[i]` cycles after release, and no later stage is reset.
- R5: `done_o` goes low in the cycle after a request is accepted. It rises once when the last stage of the run ends. While `done_o` is high, no stage reset is high.
- R6: Mode input value 0 selects sequential and 1 selects single. The mode is captured when the sequencer enters the held state. Single mode applies only if the synchronized mode has held the same value for `SETUP_CYCLES` cycles; otherwise the run is sequential.
- R7: The initialization request always runs sequentially from stage 0 and overrides any stage request that is high at the same time. Among stage requests, the lowest stage index wins.
- R8: While the synchronized override is high:
  - every stage reset is low;
  - requests are ignored;
  - `done_o` keeps its value;
  - any run in progress is abandoned, and the sequencer returns to idle.
- R9: A request accepted while a run is in progress restarts the run from the newly requested stage. The abandoned run produces no rise on `done_o`.
- R10: With `SEQ_ONLY` set, the mode input has no effect and every run is sequential.
- R11: While the synchronous reset `rst` is high, all stage resets and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req_i | input | 1 | Asynchronous full-initialization request |
| stage_req_i | input | NUM_STAGES | Asynchronous per-stage requests, bit i for stage i |
| mode_sel_i | input | 1 | Mode select: 0 sequential, 1 single |
| ovrd_i | input | 1 | Override; high suppresses sequencing |
| stage_rst_o | output | NUM_STAGES | Per-stage reset outputs, bit i for stage i |
| done_o | output | 1 | Run-complete flag |

## Verification
The bench builds the block with three stages and sequential holds of 3, 4 and 5 cycles. Single-mode holds are 7, 8 and 9 cycles, and the setup window is 8 cycles. These small values make complete runs, and single runs that end before a later stage would start, each take only tens of cycles. Because every hold count is different, a wrong stage index shows up as a wrong duration. A second instance, built as the sequential-only variant, runs on the same inputs so that the mode-ignore rule can be compared directly against the mode-capable build.

// File: rtl/stage_reset_pkg.sv
package stage_reset_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end

endmodule

// File: rtl/rst_mode_guard.sv
module rst_mode_guard #(
  parameter int unsigned SETUP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_s,
  output logic single_ok
);

  localparam int unsigned AW = $clog2(SETUP_CYCLES + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(SETUP_CYCLES);

  logic [AW-1:0] age_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= mode_s;
      if (mode_s != prev_q)
        age_q <= '0;
      else if (age_q != AGE_MAX)
        age_q <= age_q + 1'b1;
    end
  end

  assign single_ok = mode_s && (prev_q == mode_s) && (age_q == AGE_MAX);

endmodule

// File: rtl/rst_stage_fsm.sv
module rst_stage_fsm
  import stage_reset_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned CNT_W      = 8,
  parameter logic [NUM_STAGES*CNT_W-1:0] SEQ_HOLD    = '1,
  parameter logic [NUM_STAGES*CNT_W-1:0] SINGLE_HOLD = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  any_req,
  input  logic                  init_req,
  input  logic [NUM_STAGES-1:0] stage_req,
  input  logic                  ovrd,
  input  logic                  single_ok,
  output logic [NUM_STAGES-1:0] stage_rst_o,
  output logic                  done_o
);

  localparam int unsigned SW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
  localparam logic [SW-1:0] LAST = SW'(NUM_STAGES - 1);

  seq_state_e             state_q, st_n;
  logic [SW-1:0]          stage_q, stg_n, pick;
  logic [CNT_W-1:0]       cnt_q, cnt_n, lim;
  logic                   single_q, sgl_n, done_n;
  logic [NUM_STAGES-1:0]  vec_n;

  // Earliest requested stage wins; initialization always starts at stage 0.
  always_comb begin
    pick = '0;
    for (int i = NUM_STAGES - 1; i >= 0; i--)
      if (stage_req[i]) pick = SW'(i);
    if (init_req) pick = '0;
  end

  assign lim = single_q ? SINGLE_HOLD[stage_q*CNT_W +: CNT_W]
                        : SEQ_HOLD[stage_q*CNT_W +: CNT_W];

  always_comb begin
    st_n   = state_q;
    stg_n  = stage_q;
    cnt_n  = cnt_q;
    sgl_n  = single_q;
    done_n = done_o;
    if (ovrd) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else if (any_req) begin
      st_n   = ST_HOLD;
      stg_n  = pick;
      cnt_n  = '0;
      done_n = 1'b0;
      if (init_req)
        sgl_n = 1'b0;
      else if (state_q != ST_HOLD)
        sgl_n = single_ok;
    end else begin
      case (state_q)
        ST_HOLD: begin
          st_n  = ST_RUN;
          cnt_n = '0;
        end
        ST_RUN: begin
          if (cnt_q == lim - CNT_W'(1)) begin
            if (single_q || stage_q == LAST) begin
              st_n   = ST_IDLE;
              done_n = 1'b1;
            end else begin
              stg_n = stage_q + 1'b1;
              cnt_n = '0;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    vec_n = '0;
    if (st_n != ST_IDLE) vec_n[stg_n] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      stage_q     <= '0;
      cnt_q       <= '0;
      single_q    <= 1'b0;
      done_o      <= 1'b0;
      stage_rst_o <= '0;
    end else begin
      state_q     <= st_n;
      stage_q     <= stg_n;
      cnt_q       <= cnt_n;
      single_q    <= sgl_n;
      done_o      <= done_n;
      stage_rst_o <= vec_n;
    end
  end

endmodule

// File: rtl/stage_reset_seq.sv
module stage_reset_seq #(
  parameter int unsigned NUM_STAGES   = 3,
  parameter int unsigned CNT_W        = 8,
  parameter logic [NUM_STAGES*CNT_W-1:0] SEQ_HOLD    = {8'd32, 8'd16, 8'd8},
  parameter logic [NUM_STAGES*CNT_W-1:0] SINGLE_HOLD = {8'd64, 8'd48, 8'd32},
  parameter int unsigned SETUP_CYCLES = 100,
  parameter bit          SEQ_ONLY     = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_req_i,
  input  logic [NUM_STAGES-1:0] stage_req_i,
  input  logic                  mode_sel_i,
  input  logic                  ovrd_i,
  output logic [NUM_STAGES-1:0] stage_rst_o,
  output logic                  done_o
);

  localparam int unsigned SYNC_W = NUM_STAGES + 3;

  logic [SYNC_W-1:0]     sync_v;
  logic [NUM_STAGES-1:0] stage_s;
  logic                  init_s, mode_s, ovrd_s, any_req_s, single_ok;

  rst_req_sync #(.W(SYNC_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ovrd_i, mode_sel_i, init_req_i, stage_req_i}),
    .sync_o  (sync_v)
  );

  assign stage_s   = sync_v[NUM_STAGES-1:0];
  assign init_s    = sync_v[NUM_STAGES];
  assign mode_s    = sync_v[NUM_STAGES+1];
  assign ovrd_s    = sync_v[NUM_STAGES+2];
  assign any_req_s = !ovrd_s && (init_s || (|stage_s));

  generate
    if (SEQ_ONLY) begin : g_seq_only
      logic unused_mode;
      assign unused_mode = mode_s;
      assign single_ok   = 1'b0;
    end else begin : g_two_mode
      rst_mode_guard #(.SETUP_CYCLES(SETUP_CYCLES)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .mode_s    (mode_s),
        .single_ok (single_ok)
      );
    end
  endgenerate

  rst_stage_fsm #(
    .NUM_STAGES  (NUM_STAGES),
    .CNT_W       (CNT_W),
    .SEQ_HOLD    (SEQ_HOLD),
    .SINGLE_HOLD (SINGLE_HOLD)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .any_req     (any_req_s),
    .init_req    (init_s),
    .stage_req   (stage_s),
    .ovrd        (ovrd_s),
    .single_ok   (single_ok),
    .stage_rst_o (stage_rst_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/stage_reset_seq_chk.sv
module stage_reset_seq_chk #(
  parameter int unsigned NUM_STAGES = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  any_req_s,
  input logic                  ovrd_s,
  input logic [NUM_STAGES-1:0] stage_rst_o,
  input logic                  done_o
);

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_rst_o)); // R3

  AST_HELD_STAGE: assert property (@(posedge clk) disable iff (rst)
    any_req_s |=> (stage_rst_o != '0) && !done_o); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (stage_rst_o == '0)); // R5

  AST_OVRD_QUIET: assert property (@(posedge clk) disable iff (rst)
    ovrd_s |=> (stage_rst_o == '0)); // R8

  AST_OVRD_DONE_KEPT: assert property (@(posedge clk) disable iff (rst)
    ovrd_s |=> $stable(done_o)); // R8

endmodule

bind stage_reset_seq stage_reset_seq_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .any_req_s   (any_req_s),
  .ovrd_s      (ovrd_s),
  .stage_rst_o (stage_rst_o),
  .done_o      (done_o)
);

// File: tb/stage_reset_seq_bench.sv
module stage_reset_seq_bench;

  localparam int N = 3;
  localparam int CW = 8;
  localparam int SETUP = 8;
  localparam logic [N*CW-1:0] SEQ_H = {8'd5, 8'd4, 8'd3};
  localparam logic [N*CW-1:0] SGL_H = {8'd9, 8'd8, 8'd7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, mode_sel = 1'b0, ovrd = 1'b0;
  logic [N-1:0] stage_req = '0;
  logic [N-1:0] stage_rst, tx_stage_rst;
  logic done, tx_done;

  always #2 clk = ~clk;

  stage_reset_seq #(.NUM_STAGES(N), .CNT_W(CW), .SEQ_HOLD(SEQ_H), .SINGLE_HOLD(SGL_H),
    .SETUP_CYCLES(SETUP), .SEQ_ONLY(1'b0)) u_stage_reset_seq (
    .clk(clk), .rst(rst), .init_req_i(init_req), .stage_req_i(stage_req),
    .mode_sel_i(mode_sel), .ovrd_i(ovrd), .stage_rst_o(stage_rst), .done_o(done));

  stage_reset_seq #(.NUM_STAGES(N), .CNT_W(CW), .SEQ_HOLD(SEQ_H), .SINGLE_HOLD(SGL_H),
    .SETUP_CYCLES(SETUP), .SEQ_ONLY(1'b1)) u_tx (
    .clk(clk), .rst(rst), .init_req_i(init_req), .stage_req_i(stage_req),
    .mode_sel_i(mode_sel), .ovrd_i(ovrd), .stage_rst_o(tx_stage_rst), .done_o(tx_done));

  int checks = 0, errors = 0, cyc_checks = 0, cyc_errs = 0;
  string cur_tag = "R11";

  // Behavioural reference: 0 idle, 1 held, 2 running
  int m_state = 0, m_stage = 0, m_cnt = 0, m_age = 0;
  bit m_sgl = 0, m_done = 0, m_prev = 0;
  logic [N+2:0] m1 = '0, m2 = '0;

  function automatic int hold_of(bit sgl, int s);
    return sgl ? int'(SGL_H[s*CW +: CW]) : int'(SEQ_H[s*CW +: CW]);
  endfunction

  always @(posedge clk) begin
    bit ovs, inits, modes, anyr, ok;
    logic [N-1:0] reqs;
    int pick;
    if (rst) begin
      m_state = 0; m_stage = 0; m_cnt = 0; m_age = 0;
      m_sgl = 0; m_done = 0; m_prev = 0; m1 = '0; m2 = '0;
    end else begin
      reqs = m2[N-1:0]; inits = m2[N]; modes = m2[N+1]; ovs = m2[N+2];
      ok = modes && (m_prev == modes) && (m_age == SETUP);
      anyr = !ovs && (inits || reqs != '0);
      if (ovs) begin
        m_state = 0; m_cnt = 0;
      end else if (anyr) begin
        pick = 0;
        for (int i = N - 1; i >= 0; i--) if (reqs[i]) pick = i;
        if (inits) pick = 0;
        if (inits) m_sgl = 0; else if (m_state != 1) m_sgl = ok;
        m_state = 1; m_stage = pick; m_cnt = 0; m_done = 0;
      end else if (m_state == 1) begin
        m_state = 2; m_cnt = 0;
      end else if (m_state == 2) begin
        if (m_cnt == hold_of(m_sgl, m_stage) - 1) begin
          if (m_sgl || m_stage == N - 1) begin m_state = 0; m_done = 1; end
          else begin m_stage++; m_cnt = 0; end
        end else m_cnt++;
      end
      if (modes != m_prev) m_age = 0; else if (m_age < SETUP) m_age++;
      m_prev = modes;
      m2 = m1;
      m1 = {ovrd, mode_sel, init_req, stage_req};
    end
  end

  // Per-cycle comparison and observation log
  int seen[N], tx_seen[N];
  int rises = 0;
  int order_log[$];
  logic [N-1:0] last_rst = '0;
  logic last_done = 1'b0;

  initial for (int i = 0; i < N; i++) begin seen[i] = 0; tx_seen[i] = 0; end

  always @(negedge clk) begin
    logic [N-1:0] exp_v;
    if (!rst) begin
      exp_v = (m_state != 0) ? N'(1 << m_stage) : '0;
      cyc_checks++;
      if (stage_rst !== exp_v || done !== m_done) begin
        cyc_errs++;
        $display("FAIL %s: stage_rst=%b done=%b expected stage_rst=%b done=%b",
                 cur_tag, stage_rst, done, exp_v, m_done);
      end
      if (stage_rst != last_rst && stage_rst != '0)
        for (int i = 0; i < N; i++) if (stage_rst[i]) order_log.push_back(i);
      for (int i = 0; i < N; i++) begin
        seen[i] += int'(stage_rst[i]);
        tx_seen[i] += int'(tx_stage_rst[i]);
      end
      if (done && !last_done) rises++;
      last_rst = stage_rst;
      last_done = done;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", wd);
      $display("Simulation finished: %0d checks, %0d errors",
               checks + cyc_checks + 1, errors + cyc_errs + 1);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int l0, r0, s0, s1, s2, t1;
    cyc(4);
    chk("R11 stage resets low in reset", int'(stage_rst), 0);
    chk("R11 done low in reset", int'(done), 0);
    rst = 1'b0;
    cyc(12);

    // R1 latency and R2 hold, then R3 sequential run
    cur_tag = "R1/R2/R3";
    l0 = order_log.size(); r0 = rises; s2 = seen[2];
    stage_req = 3'b010;
    cyc(1); chk("R1 no effect after one edge", int'(stage_rst), 0);
    cyc(1); chk("R1 no effect after two edges", int'(stage_rst), 0);
    cyc(1); chk("R1 stage 1 reset on third edge", int'(stage_rst), 2);
    cyc(8);
    chk("R2 stage held while request high", int'(stage_rst), 2);
    chk("R2 done low while held", int'(done), 0);
    stage_req = '0;
    cyc(30);
    chk("R3 stages run count", order_log.size() - l0, 2);
    chk("R3 first stage", order_log[l0], 1);
    chk("R3 second stage", order_log[l0+1], 2);
    chk("R3 last stage hold length", seen[2] - s2, 5);
    chk("R5 done high after run", int'(done), 1);
    chk("R5 single done rise", rises - r0, 1);

    // R4 single mode, R10 sequential-only variant on the same stimulus
    cur_tag = "R4/R10";
    mode_sel = 1'b1;
    cyc(20);
    s0 = seen[0]; s1 = seen[1]; s2 = seen[2]; r0 = rises; t1 = tx_seen[1];
    stage_req = 3'b001;
    cyc(2);
    stage_req = '0;
    cyc(40);
    chk("R4 stage 0 held 2 + single hold", seen[0] - s0, 9);
    chk("R4 stage 1 untouched", seen[1] - s1, 0);
    chk("R4 stage 2 untouched", seen[2] - s2, 0);
    chk("R5 done rises after single run", rises - r0, 1);
    chk("R10 variant still ran stage 1", int'(tx_seen[1] - t1 > 0), 1);
    chk("R10 variant done", int'(tx_done), 1);

    // R6 mode change too close to the request: sequential
    cur_tag = "R6";
    mode_sel = 1'b0;
    cyc(20);
    s2 = seen[2];
    mode_sel = 1'b1;
    stage_req = 3'b010;
    cyc(2);
    stage_req = '0;
    cyc(30);
    chk("R6 unsettled mode treated as sequential", int'(seen[2] - s2 > 0), 1);

    // R7 initialization beats stage request and single mode
    cur_tag = "R7";
    cyc(20);
    l0 = order_log.size();
    init_req = 1'b1;
    stage_req = 3'b100;
    cyc(2);
    init_req = 1'b0;
    stage_req = '0;
    cyc(40);
    chk("R7 three stages run", order_log.size() - l0, 3);
    chk("R7 starts at stage 0", order_log[l0], 0);
    chk("R7 ends at last stage", order_log[l0+2], 2);
    chk("R7 done", int'(done), 1);

    // R9 restart from a new request mid-run
    cur_tag = "R9";
    mode_sel = 1'b0;
    cyc(20);
    l0 = order_log.size(); r0 = rises;
    stage_req = 3'b100;
    cyc(2);
    stage_req = '0;
    cyc(2);
    stage_req = 3'b001;
    cyc(2);
    stage_req = '0;
    cyc(40);
    chk("R9 one done rise over restart", rises - r0, 1);
    chk("R9 restarted order length", order_log.size() - l0, 4);
    chk("R9 restart goes to stage 0", order_log[l0+1], 0);

    // R8 override
    cur_tag = "R8";
    ovrd = 1'b1;
    cyc(6);
    s0 = seen[0] + seen[1] + seen[2];
    stage_req = 3'b010;
    cyc(2);
    stage_req = '0;
    cyc(20);
    chk("R8 request ignored under override", seen[0] + seen[1] + seen[2] - s0, 0);
    chk("R8 done kept under override", int'(done), 1);
    ovrd = 1'b0;
    cyc(6);
    init_req = 1'b1;
    cyc(2);
    init_req = 1'b0;
    cyc(4);
    ovrd = 1'b1;
    cyc(5);
    chk("R8 run abandoned", int'(stage_rst), 0);
    chk("R8 done stays low after abort", int'(done), 0);
    ovrd = 1'b0;
    cyc(10);
    chk("R8 idle after override release", int'(stage_rst), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks + cyc_checks, errors + cyc_errs);
    $finish;
  end

endmodule